// File: doc/BRIEF.md
# Address Translation Fault Classifier

This block sits beside a memory-management unit and decides, for every memory access, whether the address skips translation, translates through a supplied TLB lookup result, or faults. The TLB array and its search are outside the block. The block receives the lookup result (hit flag, physical and virtual page bases, and read, write and execute permissions) together with the access's virtual address, its kind, the privilege level and a flag saying whether translation is enabled.

The decision is combinational. It presents a page-aligned physical address, a success or fault flag and a cause code in the same cycle as the access. When a valid, non-probe access faults, the next clock edge updates three reporting registers. The bad-address register takes the faulting address. The page-table-entry address register takes the faulting virtual page number and keeps its table-base field. The data-side flag records whether the TLB fault came from a load or store rather than an instruction fetch. A probe access returns only the verdict.

Top module: `xlat_fault_sort`

## Requirements
- R1: With mmuOn low, a valid access always reports accDone=1 and accFault=0, and physAddr equals vaddr with its low 12 bits cleared, whatever the privilege, address or lookup inputs.
- R2: With mmuOn high and isSuper high, an address at or above 0xC0000000 completes with physAddr equal to the page-aligned vaddr, and the lookup inputs are ignored.
- R3: With mmuOn high and isSuper low, an address at or above 0x80000000 faults with faultCause 1. The next edge loads badAddrReg with vaddr and leaves pteAddrReg and tlbDataFlag unchanged.
- R4: For an address not covered by R1 to R3, a TLB hit whose permission matches the access kind (accKind 0 load needs permRd, 1 store needs permWr, 2 fetch needs permEx) completes with physAddr = hitPhysBase + page-aligned vaddr − hitVirtBase, and faultCause 0.
- R5: A hit without the matching permission faults with faultCause 3 for a load, 4 for a store and 5 for a fetch.
- R6: A TLB miss faults with faultCause 2.
- R7: On a TLB fault (cause 2 to 5), the next edge sets tlbDataFlag for a load or store and clears it for a fetch.
- R8: On a TLB fault, the next edge loads pteAddrReg bits [21:2] with vaddr[31:12], keeps bits [31:22] (the table base), holds bits [1:0] at zero, and loads badAddrReg with vaddr.
- R9: With probe high, a faulting access still reports accFault and faultCause but changes none of badAddrReg, pteAddrReg and tlbDataFlag.
- R10: With accValid low, accDone, accFault and faultCause are all zero and no register changes.
- R11: After reset, badAddrReg is 0, tlbDataFlag is 0 and pteAddrReg holds the table base parameter in bits [31:22] and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | An access is presented this cycle |
| vaddr | input | 32 | Virtual address of the access |
| accKind | input | 2 | 0 load, 1 store, 2 fetch |
| isSuper | input | 1 | Access runs at supervisor privilege |
| mmuOn | input | 1 | Translation hardware present and enabled |
| probe | input | 1 | Report the verdict only, no register update |
| tlbHit | input | 1 | Lookup found a matching entry |
| hitPhysBase | input | 32 | Physical page base of the matching entry |
| hitVirtBase | input | 32 | Virtual page base of the matching entry |
| permRd | input | 1 | Entry allows reads |
| permWr | input | 1 | Entry allows writes |
| permEx | input | 1 | Entry allows execution |
| physAddr | output | 32 | Page-aligned physical address, meaningful with accDone |
| accDone | output | 1 | Access completes |
| accFault | output | 1 | Access faults |
| faultCause | output | 3 | 0 none, 1 privileged address, 2 miss, 3 read, 4 write, 5 execute |
| badAddrReg | output | 32 | Address of the last committed fault |
| pteAddrReg | output | 32 | Table base and faulting page number |
| tlbDataFlag | output | 1 | Last TLB fault came from a data access |

## Verification
The assertions assume that accKind never carries the unused code 3. They also assume that hitPhysBase and hitVirtBase are page-aligned whenever tlbHit is high, because the translation sum carries any low bits straight into physAddr. The stimulus drives only the three defined access kinds and uses bases with their low 12 bits clear. It changes inputs only on the falling edge, so the combinational verdict has settled before each rising edge commits the registers.

// File: rtl/xfs_pkg.sv
package xfs_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2
  } accKind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_PRIV_ADDR = 3'd1,
    CAUSE_TLB_MISS  = 3'd2,
    CAUSE_NO_READ   = 3'd3,
    CAUSE_NO_WRITE  = 3'd4,
    CAUSE_NO_EXEC   = 3'd5
  } cause_e;

  // strobes from the classifier to the datapath
  typedef struct packed {
    logic useXlate;   // select the translated page address
    logic loadBad;    // capture the faulting address
    logic loadPte;    // capture the faulting page number
    logic markData;   // TLB fault came from a load or store
    logic markInstr;  // TLB fault came from a fetch
  } strobe_t;

endpackage

// File: rtl/xfs_ctrl.sv
module xfs_ctrl
  import xfs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] SUP_BYPASS_BASE = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] USER_LIMIT      = 32'h8000_0000
) (
  input  logic              accValid,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        accKind,
  input  logic              isSuper,
  input  logic              mmuOn,
  input  logic              probe,
  input  logic              tlbHit,
  input  logic              permRd,
  input  logic              permWr,
  input  logic              permEx,
  output strobe_t           strb,
  output logic              faultRaw,
  output logic [2:0]        causeRaw
);

  accKind_e kind;
  logic     permOk;
  cause_e   permCause;
  cause_e   cause;
  logic     tlbFault;
  logic     useXlate;
  logic     commit;

  assign kind = accKind_e'(accKind);

  always_comb begin
    unique case (kind)
      KIND_LOAD:  begin permOk = permRd; permCause = CAUSE_NO_READ;  end
      KIND_STORE: begin permOk = permWr; permCause = CAUSE_NO_WRITE; end
      default:    begin permOk = permEx; permCause = CAUSE_NO_EXEC;  end
    endcase
  end

  // region and privilege rules come before the lookup result
  always_comb begin
    cause    = CAUSE_NONE;
    faultRaw = 1'b0;
    tlbFault = 1'b0;
    useXlate = 1'b0;
    if (!mmuOn) begin
      // identity mapping, always completes
    end else if (isSuper && (vaddr >= SUP_BYPASS_BASE)) begin
      // supervisor window mapped one to one
    end else if (!isSuper && (vaddr >= USER_LIMIT)) begin
      faultRaw = 1'b1;
      cause    = CAUSE_PRIV_ADDR;
    end else if (tlbHit) begin
      if (permOk) begin
        useXlate = 1'b1;
      end else begin
        faultRaw = 1'b1;
        tlbFault = 1'b1;
        cause    = permCause;
      end
    end else begin
      faultRaw = 1'b1;
      tlbFault = 1'b1;
      cause    = CAUSE_TLB_MISS;
    end
  end

  assign commit         = accValid && !probe && faultRaw;
  assign strb.useXlate  = useXlate;
  assign strb.loadBad   = commit;
  assign strb.loadPte   = commit && tlbFault;
  assign strb.markData  = commit && tlbFault && (kind != KIND_FETCH);
  assign strb.markInstr = commit && tlbFault && (kind == KIND_FETCH);
  assign causeRaw       = cause;

endmodule

// File: rtl/xfs_dpath.sv
module xfs_dpath
  import xfs_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned PAGE_BITS     = 12,
  parameter int unsigned VPN_LO        = 2,
  parameter int unsigned TBL_BASE_INIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] hitPhysBase,
  input  logic [ADDR_W-1:0] hitVirtBase,
  output logic [ADDR_W-1:0] physAddr,
  output logic [ADDR_W-1:0] badAddrReg,
  output logic [ADDR_W-1:0] pteAddrReg,
  output logic              tlbDataFlag
);

  localparam int unsigned VPN_W   = ADDR_W - PAGE_BITS;
  localparam int unsigned TBASE_W = ADDR_W - VPN_LO - VPN_W;
  localparam logic [TBASE_W-1:0] TBASE_RST = TBASE_W'(TBL_BASE_INIT);

  logic [ADDR_W-1:0] pageAlign;
  logic [ADDR_W-1:0] xlatAddr;
  logic [VPN_W-1:0]  pteVpn;

  assign pageAlign = {vaddr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  assign xlatAddr  = hitPhysBase + pageAlign - hitVirtBase;
  assign physAddr  = strb.useXlate ? xlatAddr : pageAlign;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badAddrReg  <= '0;
      pteVpn      <= '0;
      tlbDataFlag <= 1'b0;
    end else begin
      if (strb.loadBad) badAddrReg <= vaddr;
      if (strb.loadPte) pteVpn <= vaddr[ADDR_W-1:PAGE_BITS];
      if (strb.markData) tlbDataFlag <= 1'b1;
      else if (strb.markInstr) tlbDataFlag <= 1'b0;
    end
  end

  // the table base is never written by a fault, only the page field
  assign pteAddrReg = {TBASE_RST, pteVpn, {VPN_LO{1'b0}}};

endmodule

// File: rtl/xlat_fault_sort.sv
module xlat_fault_sort
  import xfs_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned PAGE_BITS     = 12,
  parameter int unsigned VPN_LO        = 2,
  parameter int unsigned TBL_BASE_INIT = 0,
  parameter logic [ADDR_W-1:0] SUP_BYPASS_BASE = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] USER_LIMIT      = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        accKind,
  input  logic              isSuper,
  input  logic              mmuOn,
  input  logic              probe,
  input  logic              tlbHit,
  input  logic [ADDR_W-1:0] hitPhysBase,
  input  logic [ADDR_W-1:0] hitVirtBase,
  input  logic              permRd,
  input  logic              permWr,
  input  logic              permEx,
  output logic [ADDR_W-1:0] physAddr,
  output logic              accDone,
  output logic              accFault,
  output logic [2:0]        faultCause,
  output logic [ADDR_W-1:0] badAddrReg,
  output logic [ADDR_W-1:0] pteAddrReg,
  output logic              tlbDataFlag
);

  strobe_t    strb;
  logic       faultRaw;
  logic [2:0] causeRaw;

  xfs_ctrl #(
    .ADDR_W(ADDR_W), .SUP_BYPASS_BASE(SUP_BYPASS_BASE), .USER_LIMIT(USER_LIMIT)
  ) u_ctrl (
    .accValid(accValid), .vaddr(vaddr), .accKind(accKind), .isSuper(isSuper),
    .mmuOn(mmuOn), .probe(probe), .tlbHit(tlbHit), .permRd(permRd),
    .permWr(permWr), .permEx(permEx), .strb(strb), .faultRaw(faultRaw),
    .causeRaw(causeRaw)
  );

  xfs_dpath #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .VPN_LO(VPN_LO),
    .TBL_BASE_INIT(TBL_BASE_INIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .vaddr(vaddr),
    .hitPhysBase(hitPhysBase), .hitVirtBase(hitVirtBase), .physAddr(physAddr),
    .badAddrReg(badAddrReg), .pteAddrReg(pteAddrReg), .tlbDataFlag(tlbDataFlag)
  );

  assign accDone    = accValid && !faultRaw;
  assign accFault   = accValid && faultRaw;
  assign faultCause = accFault ? causeRaw : 3'd0;

endmodule

// File: rtl/xfs_chk.sv
module xfs_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] USER_LIMIT = 32'h8000_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic [ADDR_W-1:0] vaddr,
  input logic [1:0]        accKind,
  input logic              isSuper,
  input logic              mmuOn,
  input logic              probe,
  input logic              accDone,
  input logic              accFault,
  input logic [2:0]        faultCause,
  input logic [ADDR_W-1:0] badAddrReg,
  input logic [ADDR_W-1:0] pteAddrReg,
  input logic              tlbDataFlag
);

  // R1: translation off never faults
  a_r1_off_completes: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !mmuOn) |-> (accDone && !accFault));

  // R3: user access to the upper region faults as privileged address
  a_r3_user_high: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && mmuOn && !isSuper && (vaddr >= USER_LIMIT))
      |-> (accFault && faultCause == 3'd1));

  // R3: a privileged-address fault leaves the TLB reporting state alone
  a_r3_tlb_state_kept: assert property (@(posedge clk) disable iff (!rstN)
    (accFault && !probe && faultCause == 3'd1)
      |=> ($stable(pteAddrReg) && $stable(tlbDataFlag)));

  // R7: a committed fetch TLB fault clears the data flag
  a_r7_fetch_clears: assert property (@(posedge clk) disable iff (!rstN)
    (accFault && !probe && faultCause >= 3'd2 && accKind == 2'd2)
      |=> !tlbDataFlag);

  // R8: a committed fault captures the address
  a_r8_bad_capture: assert property (@(posedge clk) disable iff (!rstN)
    (accFault && !probe) |=> (badAddrReg == $past(vaddr)));

  // R9: probes leave all reporting state alone
  a_r9_probe_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && probe) |=> ($stable(badAddrReg) && $stable(pteAddrReg)
                             && $stable(tlbDataFlag)));

  // R10: no verdict and no update while idle
  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!accDone && !accFault && faultCause == 3'd0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> $stable(badAddrReg));

  // R4: done and fault are exclusive
  a_r4_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accDone, accFault}));

endmodule

bind xlat_fault_sort xfs_chk #(.ADDR_W(ADDR_W), .USER_LIMIT(USER_LIMIT)) u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .vaddr(vaddr),
  .accKind(accKind), .isSuper(isSuper), .mmuOn(mmuOn), .probe(probe),
  .accDone(accDone), .accFault(accFault), .faultCause(faultCause),
  .badAddrReg(badAddrReg), .pteAddrReg(pteAddrReg), .tlbDataFlag(tlbDataFlag)
);

// File: tb/sim_xlat_fault_sort.sv
module sim_xlat_fault_sort;

  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] TBL = 10'h2A5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  accKind = '0;
  logic        isSuper = 1'b0;
  logic        mmuOn = 1'b0;
  logic        probe = 1'b0;
  logic        tlbHit = 1'b0;
  logic [31:0] hitPhysBase = '0;
  logic [31:0] hitVirtBase = '0;
  logic        permRd = 1'b0;
  logic        permWr = 1'b0;
  logic        permEx = 1'b0;
  logic [31:0] physAddr;
  logic        accDone;
  logic        accFault;
  logic [2:0]  faultCause;
  logic [31:0] badAddrReg;
  logic [31:0] pteAddrReg;
  logic        tlbDataFlag;

  int nChecks = 0;
  int nFail = 0;
  logic finished = 1'b0;

  logic [31:0] expBad;
  logic [31:0] expPte;
  logic        expFlag;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_fault_sort #(.TBL_BASE_INIT(int'(TBL))) u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .vaddr(vaddr),
    .accKind(accKind), .isSuper(isSuper), .mmuOn(mmuOn), .probe(probe),
    .tlbHit(tlbHit), .hitPhysBase(hitPhysBase), .hitVirtBase(hitVirtBase),
    .permRd(permRd), .permWr(permWr), .permEx(permEx), .physAddr(physAddr),
    .accDone(accDone), .accFault(accFault), .faultCause(faultCause),
    .badAddrReg(badAddrReg), .pteAddrReg(pteAddrReg), .tlbDataFlag(tlbDataFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pteOf(input logic [31:0] va);
    return {TBL, va[31:12], 2'b00};
  endfunction

  // drive one access on the falling edge; perm is {x,w,r}
  task automatic drive(input logic [31:0] va, input logic [1:0] kd,
                       input logic sup, input logic mmu, input logic prb,
                       input logic vld, input logic hit,
                       input logic [31:0] pb, input logic [31:0] vb,
                       input logic [2:0] perm);
    @(negedge clk);
    vaddr = va; accKind = kd; isSuper = sup; mmuOn = mmu; probe = prb;
    accValid = vld; tlbHit = hit; hitPhysBase = pb; hitVirtBase = vb;
    {permEx, permWr, permRd} = perm;
    #1;
  endtask

  task automatic checkVerdict(input string tag, input logic done,
                              input logic [2:0] cause, input logic [31:0] pa,
                              input logic checkPa);
    chk({tag, " done"}, {31'd0, accDone}, {31'd0, done});
    chk({tag, " fault"}, {31'd0, accFault}, {31'd0, ~done & accValid});
    chk({tag, " cause"}, {29'd0, faultCause}, {29'd0, cause});
    if (checkPa) chk({tag, " phys"}, physAddr, pa);
  endtask

  task automatic checkRegs(input string tag);
    @(posedge clk); #1;
    chk({tag, " badAddr"}, badAddrReg, expBad);
    chk({tag, " pteAddr"}, pteAddrReg, expPte);
    chk({tag, " dataFlag"}, {31'd0, tlbDataFlag}, {31'd0, expFlag});
  endtask

  task automatic tReset();
    checkRegs("R11 reset");
  endtask

  task automatic tNoMmu();
    drive(32'h1234_5678, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 3'b000);
    checkVerdict("R1 off low", 1'b1, 3'd0, 32'h1234_5000, 1'b1);
    checkRegs("R1 off low");
    drive(32'hF000_0010, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 3'b000);
    checkVerdict("R1 off user high", 1'b1, 3'd0, 32'hF000_0000, 1'b1);
    checkRegs("R1 off user high");
  endtask

  task automatic tSupBypass();
    drive(32'hC000_1ABC, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h1111_1000, 32'h0, 3'b000);
    checkVerdict("R2 sup bypass", 1'b1, 3'd0, 32'hC000_1000, 1'b1);
    checkRegs("R2 sup bypass");
  endtask

  task automatic tUserHigh();
    drive(32'h9000_0004, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0, 32'h9000_0000, 3'b111);
    checkVerdict("R3 user high", 1'b0, 3'd1, 32'h0, 1'b0);
    expBad = 32'h9000_0004;
    checkRegs("R3 user high");
  endtask

  task automatic tHitOk();
    drive(32'h0040_3123, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0770_0000, 32'h0040_0000, 3'b001);
    checkVerdict("R4 user load hit", 1'b1, 3'd0, 32'h0770_3000, 1'b1);
    checkRegs("R4 user load hit");
    drive(32'h8800_2000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h1000_0000, 32'h8800_0000, 3'b100);
    checkVerdict("R4 sup fetch hit", 1'b1, 3'd0, 32'h1000_2000, 1'b1);
    checkRegs("R4 sup fetch hit");
  endtask

  task automatic tPermFault();
    drive(32'h00AB_C123, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0, 32'h00AB_C000, 3'b101);
    checkVerdict("R5 store no write", 1'b0, 3'd4, 32'h0, 1'b0);
    expBad = 32'h00AB_C123; expPte = pteOf(32'h00AB_C123); expFlag = 1'b1;
    checkRegs("R7 R8 store fault");
    drive(32'h0123_4567, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0, 32'h0123_4000, 3'b011);
    checkVerdict("R5 fetch no exec", 1'b0, 3'd5, 32'h0, 1'b0);
    expBad = 32'h0123_4567; expPte = pteOf(32'h0123_4567); expFlag = 1'b0;
    checkRegs("R7 R8 fetch fault");
    drive(32'h0055_5008, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0, 32'h0055_5000, 3'b110);
    checkVerdict("R5 load no read", 1'b0, 3'd3, 32'h0, 1'b0);
    expBad = 32'h0055_5008; expPte = pteOf(32'h0055_5008); expFlag = 1'b1;
    checkRegs("R7 R8 load fault");
  endtask

  task automatic tMiss();
    drive(32'h8123_4ABC, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 3'b111);
    checkVerdict("R6 sup fetch miss", 1'b0, 3'd2, 32'h0, 1'b0);
    expBad = 32'h8123_4ABC; expPte = pteOf(32'h8123_4ABC); expFlag = 1'b0;
    checkRegs("R6 R7 R8 miss");
    drive(32'h7FFF_F010, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 3'b111);
    checkVerdict("R6 user store miss", 1'b0, 3'd2, 32'h0, 1'b0);
    expBad = 32'h7FFF_F010; expPte = pteOf(32'h7FFF_F010); expFlag = 1'b1;
    checkRegs("R6 R7 R8 miss store");
  endtask

  task automatic tProbe();
    drive(32'h00F0_0000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 3'b000);
    checkVerdict("R9 probe miss", 1'b0, 3'd2, 32'h0, 1'b0);
    checkRegs("R9 probe miss");
    drive(32'hA000_0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 3'b000);
    checkVerdict("R9 probe user high", 1'b0, 3'd1, 32'h0, 1'b0);
    checkRegs("R9 probe user high");
  endtask

  task automatic tIdle();
    drive(32'h0BAD_0000, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 3'b000);
    checkVerdict("R10 idle", 1'b0, 3'd0, 32'h0, 1'b0);
    checkRegs("R10 idle");
  endtask

  initial begin
    expBad = '0; expPte = {TBL, 22'd0}; expFlag = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tReset();
    tNoMmu();
    tSupBypass();
    tUserHigh();
    tHitOk();
    tPermFault();
    tMiss();
    tProbe();
    tIdle();
    @(negedge clk); accValid = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule